// File: doc/BRIEF.md
# Paired Port Register Bank

This block is the register bank of a 16-pin, two-port I/O expander. A byte-oriented two-wire slave front end, which is not part of the block, decodes bus conditions and bytes and presents them here as single-cycle strobes: start of a write transaction, start of a read transaction, stop, a received byte, a request for the next byte to transmit, and the master's acknowledge decision for a transmitted byte. The bank holds four register groups (pin input, output data, polarity inversion and direction configuration), each made of two 8-bit registers, one for pins 7..0 and one for pins 15..8.

A write transaction carries a command byte followed by data bytes. The command byte selects a group and a starting port. Each later byte lands in the selected register, and the port half of the pointer then flips, so a burst alternates between the two registers of the pair instead of walking through the map. Reads work the same way. A read of an input register captures the pin levels of that port at the moment of the read, with polarity inversion applied. A read burst continues until the master declines to acknowledge a byte. The direction registers drive the pin output enables, and the output registers drive the pin data.

The controller is a five-state machine. `ST_IDLE` is entered on reset and on stop. `ST_CMD` is entered on a write start and leaves for `ST_WDATA` when the first byte arrives. `ST_WDATA` stays put and commits each byte. `ST_RDATA` is entered on a read start; a not-acknowledged byte moves it to `ST_RDONE`, which waits for the next start or stop. From any state, stop goes to `ST_IDLE`, a write start to `ST_CMD` and a read start to `ST_RDATA`, with stop winning over the starts. A strobe that arrives in the same cycle as a start or stop is not acted on.

Top module: `pair_port_bank`

## Requirements
- R1: After reset, all output data registers are all ones, all polarity registers are zero, all direction registers are all ones (every pin an input, so `pin_oe` = 0 and `pin_od` = all ones), the pointer is 0 and `rd_byte` is 0.
- R2: In `ST_CMD` the first received byte sets the pointer from its bits [2:0]. Bits [2:1] pick the group (0 pin input, 1 output data, 2 polarity, 3 direction) and bit 0 picks the port (0 = pins 7..0, 1 = pins 15..8). The higher bits are ignored, and the command byte is stored in no register.
- R3: In `ST_WDATA` each received byte is stored in the addressed register and is visible at the outputs on the clock edge after `wr_stb`. Pointer bit 0 then flips, so consecutive bytes alternate between the two ports of the group.
- R4: A data byte addressed to the pin input group changes no register and no output, but the pointer still flips.
- R5: In `ST_RDATA` each `rd_stb` loads `rd_byte` from the addressed register and flips pointer bit 0, for any number of bytes.
- R6: A read of the pin input group returns that port's pin levels XOR its polarity bits, captured at `rd_stb` and held until the next accepted `rd_stb`, whatever the pin directions are.
- R7: `pin_oe[i]` is the inverse of direction bit i, and `pin_od[i]` is output data bit i.
- R8: `rd_ack_stb` with `rd_acked` = 0 in `ST_RDATA` ends the burst. Later `rd_stb` pulses leave `rd_byte` and the pointer unchanged until a new start. With `rd_acked` = 1 the burst continues.
- R9: A read start keeps the pointer left by the previous transaction. In `ST_IDLE`, `wr_stb` and `rd_stb` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| start_wr | input | 1 | Start condition addressed for a write |
| start_rd | input | 1 | Start condition addressed for a read |
| stop | input | 1 | Stop condition |
| wr_stb | input | 1 | Received byte, pulsed at the end of its acknowledge clock |
| wr_byte | input | PORT_W | Received byte value |
| rd_stb | input | 1 | Front end requests the next byte to transmit |
| rd_ack_stb | input | 1 | Master acknowledge slot for a transmitted byte |
| rd_acked | input | 1 | 1 = acknowledged, 0 = not acknowledged |
| pin_in | input | 2*PORT_W | Pin levels |
| rd_byte | output | PORT_W | Byte to transmit |
| pin_oe | output | 2*PORT_W | Per-pin output enable |
| pin_od | output | 2*PORT_W | Per-pin output data |

## Verification
The bench builds the block with the default PORT_W of 8. At that width the full byte values of the command and data paths, including command bytes with high bits set, can be reached, and both ports of every group can be exercised in alternating bursts. Directed sequences cover the pointer flip, pin capture under polarity inversion, burst end on a missing acknowledge and repeated-start pointer retention. A random phase with mixed strobes and changing pins is then compared every cycle against a behavioural model.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    localparam int PTR_W = 3;
    localparam int NPORT = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_RDONE = 3'd4
    } bus_st_e;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_CFG = 2'd3
    } grp_e;
endpackage

// File: rtl/ppb_ctrl.sv
module ppb_ctrl
    import ppb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             start_rd,
    input  logic             stop,
    input  logic             wr_stb,
    input  logic [PTR_W-1:0] cmd_lo,
    input  logic             rd_stb,
    input  logic             rd_ack_stb,
    input  logic             rd_acked,
    output bus_st_e          st,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic             rd_en
);
    bus_st_e          st_q, st_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             bus_evt;

    assign bus_evt = stop | start_wr | start_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d = ST_IDLE;
        end else if (start_wr) begin
            st_d = ST_CMD;
        end else if (start_rd) begin
            st_d = ST_RDATA;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_CMD:   if (wr_stb) st_d = ST_WDATA;
                ST_WDATA: st_d = ST_WDATA;
                ST_RDATA: if (rd_ack_stb && !rd_acked) st_d = ST_RDONE;
                ST_RDONE: st_d = ST_RDONE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // outputs and pointer
    always_comb begin
        wr_en = (st_q == ST_WDATA) && wr_stb && !bus_evt;
        rd_en = (st_q == ST_RDATA) && rd_stb && !bus_evt;
        ptr_d = ptr_q;
        if ((st_q == ST_CMD) && wr_stb && !bus_evt) begin
            ptr_d = cmd_lo;
        end else if (wr_en || rd_en) begin
            ptr_d = {ptr_q[PTR_W-1:1], ~ptr_q[0]};
        end
    end

    assign st  = st_q;
    assign ptr = ptr_q;
endmodule

// File: rtl/ppb_regs.sv
module ppb_regs
    import ppb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        ptr,
    input  logic [PORT_W-1:0]       wdata,
    output logic [NPORT*PORT_W-1:0] out_q,
    output logic [NPORT*PORT_W-1:0] pol_q,
    output logic [NPORT*PORT_W-1:0] cfg_q
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [PORT_W-1:0] out_r, pol_r, cfg_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_r <= '1;
                pol_r <= '0;
                cfg_r <= '1;
            end else if (wr_en && (ptr[0] == 1'(p))) begin
                unique case (grp_e'(ptr[PTR_W-1:1]))
                    GRP_OUT: out_r <= wdata;
                    GRP_POL: pol_r <= wdata;
                    GRP_CFG: cfg_r <= wdata;
                    default: ;
                endcase
            end
        end

        assign out_q[p*PORT_W +: PORT_W] = out_r;
        assign pol_q[p*PORT_W +: PORT_W] = pol_r;
        assign cfg_q[p*PORT_W +: PORT_W] = cfg_r;
    end
endmodule

// File: rtl/ppb_rdsel.sv
module ppb_rdsel
    import ppb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [PTR_W-1:0]        ptr,
    input  logic [NPORT*PORT_W-1:0] pin_in,
    input  logic [NPORT*PORT_W-1:0] out_q,
    input  logic [NPORT*PORT_W-1:0] pol_q,
    input  logic [NPORT*PORT_W-1:0] cfg_q,
    output logic [PORT_W-1:0]       rd_byte
);
    localparam int HI = NPORT * PORT_W - 1;

    logic [PORT_W-1:0] sel_v, pin_v, out_v, pol_v, cfg_v;

    always_comb begin
        pin_v = ptr[0] ? pin_in[HI:PORT_W] : pin_in[PORT_W-1:0];
        out_v = ptr[0] ? out_q[HI:PORT_W]  : out_q[PORT_W-1:0];
        pol_v = ptr[0] ? pol_q[HI:PORT_W]  : pol_q[PORT_W-1:0];
        cfg_v = ptr[0] ? cfg_q[HI:PORT_W]  : cfg_q[PORT_W-1:0];
        unique case (grp_e'(ptr[PTR_W-1:1]))
            GRP_IN:  sel_v = pin_v ^ pol_v;
            GRP_OUT: sel_v = out_v;
            GRP_POL: sel_v = pol_v;
            GRP_CFG: sel_v = cfg_v;
            default: sel_v = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (rd_en) begin
            rd_byte <= sel_v;
        end
    end
endmodule

// File: rtl/pair_port_bank.sv
module pair_port_bank
    import ppb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_wr,
    input  logic                    start_rd,
    input  logic                    stop,
    input  logic                    wr_stb,
    input  logic [PORT_W-1:0]       wr_byte,
    input  logic                    rd_stb,
    input  logic                    rd_ack_stb,
    input  logic                    rd_acked,
    input  logic [NPORT*PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0]       rd_byte,
    output logic [NPORT*PORT_W-1:0] pin_oe,
    output logic [NPORT*PORT_W-1:0] pin_od
);
    bus_st_e                 st;
    logic [PTR_W-1:0]        ptr;
    logic                    wr_en, rd_en;
    logic [NPORT*PORT_W-1:0] out_q, pol_q, cfg_q;

    ppb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .stop       (stop),
        .wr_stb     (wr_stb),
        .cmd_lo     (wr_byte[PTR_W-1:0]),
        .rd_stb     (rd_stb),
        .rd_ack_stb (rd_ack_stb),
        .rd_acked   (rd_acked),
        .st         (st),
        .ptr        (ptr),
        .wr_en      (wr_en),
        .rd_en      (rd_en)
    );

    ppb_regs #(.PORT_W(PORT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .ptr   (ptr),
        .wdata (wr_byte),
        .out_q (out_q),
        .pol_q (pol_q),
        .cfg_q (cfg_q)
    );

    ppb_rdsel #(.PORT_W(PORT_W)) u_rdsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .ptr     (ptr),
        .pin_in  (pin_in),
        .out_q   (out_q),
        .pol_q   (pol_q),
        .cfg_q   (cfg_q),
        .rd_byte (rd_byte)
    );

    assign pin_oe = ~cfg_q;
    assign pin_od = out_q;
endmodule

// File: rtl/ppb_chk.sv
module ppb_chk
    import ppb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_wr,
    input logic                    start_rd,
    input logic                    stop,
    input logic [PORT_W-1:0]       wr_byte,
    input logic                    rd_ack_stb,
    input logic                    rd_acked,
    input logic [PORT_W-1:0]       rd_byte,
    input logic [NPORT*PORT_W-1:0] pin_oe,
    input logic [NPORT*PORT_W-1:0] pin_od,
    input bus_st_e                 st,
    input logic [PTR_W-1:0]        ptr,
    input logic                    wr_en,
    input logic                    rd_en
);
    // R3 R5
    ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |=> (ptr[0] != $past(ptr[0])) && (ptr[PTR_W-1:1] == $past(ptr[PTR_W-1:1])));

    // R3
    out_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 3'b010) |=> pin_od[PORT_W-1:0] == $past(wr_byte));

    // R7
    cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 3'b111) |=> pin_oe[NPORT*PORT_W-1:PORT_W] == ~$past(wr_byte));

    // R4
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr[PTR_W-1:1] == 2'b00) |=> $stable(pin_od) && $stable(pin_oe));

    // R9
    no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_od) && $stable(pin_oe));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_byte));

    // R8
    nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDATA && rd_ack_stb && !rd_acked && !start_wr && !start_rd && !stop)
        |=> st == ST_RDONE);
endmodule

bind pair_port_bank ppb_chk #(.PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr   (start_wr),
    .start_rd   (start_rd),
    .stop       (stop),
    .wr_byte    (wr_byte),
    .rd_ack_stb (rd_ack_stb),
    .rd_acked   (rd_acked),
    .rd_byte    (rd_byte),
    .pin_oe     (pin_oe),
    .pin_od     (pin_od),
    .st         (st),
    .ptr        (ptr),
    .wr_en      (wr_en),
    .rd_en      (rd_en)
);

// File: tb/sim_pair_port_bank.sv
module sim_pair_port_bank;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         start_wr = 0, start_rd = 0, stop = 0;
    logic         wr_stb = 0, rd_stb = 0, rd_ack_stb = 0, rd_acked = 0;
    logic [W-1:0] wr_byte = '0;
    logic [2*W-1:0] pin_in = '0;
    logic [W-1:0]   rd_byte;
    logic [2*W-1:0] pin_oe, pin_od;

    pair_port_bank #(.PORT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .stop(stop), .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb),
        .rd_ack_stb(rd_ack_stb), .rd_acked(rd_acked), .pin_in(pin_in),
        .rd_byte(rd_byte), .pin_oe(pin_oe), .pin_od(pin_od)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model: 0 idle, 1 cmd, 2 wdata, 3 rdata, 4 rdone
    logic [W-1:0] m_out [2];
    logic [W-1:0] m_pol [2];
    logic [W-1:0] m_cfg [2];
    logic [W-1:0] m_rd;
    int           m_st;
    int           m_ptr;

    function automatic logic [W-1:0] m_val(int p);
        logic [W-1:0] pins;
        pins = (p % 2 == 1) ? pin_in[2*W-1:W] : pin_in[W-1:0];
        case (p / 2)
            0: return pins ^ m_pol[p % 2];
            1: return m_out[p % 2];
            2: return m_pol[p % 2];
            default: return m_cfg[p % 2];
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out[0] = '1; m_out[1] = '1;
            m_pol[0] = '0; m_pol[1] = '0;
            m_cfg[0] = '1; m_cfg[1] = '1;
            m_rd = '0; m_st = 0; m_ptr = 0;
        end else if (stop) begin
            m_st = 0;
        end else if (start_wr) begin
            m_st = 1;
        end else if (start_rd) begin
            m_st = 3;
        end else begin
            case (m_st)
                1: if (wr_stb) begin m_ptr = int'(wr_byte) % 8; m_st = 2; end
                2: if (wr_stb) begin
                    case (m_ptr / 2)
                        1: m_out[m_ptr % 2] = wr_byte;
                        2: m_pol[m_ptr % 2] = wr_byte;
                        3: m_cfg[m_ptr % 2] = wr_byte;
                        default: ;
                    endcase
                    m_ptr = m_ptr ^ 1;
                end
                3: if (rd_stb) begin
                    m_rd = m_val(m_ptr);
                    m_ptr = m_ptr ^ 1;
                end else if (rd_ack_stb && !rd_acked) begin
                    m_st = 4;
                end
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 pin_od model", pin_od, {m_out[1], m_out[0]});
            check("R7 pin_oe model", pin_oe, ~{m_cfg[1], m_cfg[0]});
            check("R5 rd_byte model", {{W{1'b0}}, rd_byte}, {{W{1'b0}}, m_rd});
        end
    end

    task automatic pulse_start_wr;
        @(negedge clk) start_wr = 1;
        @(negedge clk) start_wr = 0;
    endtask
    task automatic pulse_start_rd;
        @(negedge clk) start_rd = 1;
        @(negedge clk) start_rd = 0;
    endtask
    task automatic pulse_stop;
        @(negedge clk) stop = 1;
        @(negedge clk) stop = 0;
    endtask
    task automatic put(logic [W-1:0] b);
        @(negedge clk) begin wr_stb = 1; wr_byte = b; end
        @(negedge clk) wr_stb = 0;
    endtask
    task automatic fetch;
        @(negedge clk) rd_stb = 1;
        @(negedge clk) rd_stb = 0;
    endtask
    task automatic ack(logic a);
        @(negedge clk) begin rd_ack_stb = 1; rd_acked = a; end
        @(negedge clk) rd_ack_stb = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_od reset", pin_od, 16'hFFFF);
        check("R1 pin_oe reset", pin_oe, 16'h0000);
        check("R1 rd_byte reset", {8'h00, rd_byte}, 16'h0000);

        // R2 R3 output pair burst
        pulse_start_wr(); put(8'h02); put(8'hA5); put(8'h3C);
        check("R3 output burst", pin_od, 16'h3CA5);
        check("R2 command not stored", pin_oe, 16'h0000);

        // R7 direction pair
        pulse_start_wr(); put(8'h06); put(8'hF0); put(8'h0F);
        check("R7 pin_oe from direction", pin_oe, 16'hF00F);
        check("R7 pin_od unchanged", pin_od, 16'h3CA5);

        // R4 writes to input group, R2 high command bits ignored
        pulse_start_wr(); put(8'hF8); put(8'h12); put(8'h34);
        check("R4 input write ignored od", pin_od, 16'h3CA5);
        check("R4 input write ignored oe", pin_oe, 16'hF00F);

        // polarity port 0 = FF, port 1 = 00
        pulse_start_wr(); put(8'h04); put(8'hFF); put(8'h00); pulse_stop();

        // R6 R5 input reads
        pulse_start_wr(); put(8'h00);
        pulse_start_rd();
        pin_in = 16'h5AC3;
        fetch();
        check("R6 input port0 inverted", {8'h00, rd_byte}, 16'h003C);
        ack(1'b1);
        pin_in = 16'h0000;
        @(negedge clk);
        check("R6 captured value held", {8'h00, rd_byte}, 16'h003C);
        fetch();
        check("R5 second byte is port1", {8'h00, rd_byte}, 16'h0000);
        ack(1'b1);
        fetch();
        check("R5 third byte back to port0", {8'h00, rd_byte}, 16'h00FF);

        // R8 burst ends on missing acknowledge
        ack(1'b0);
        pin_in = 16'hA500;
        fetch();
        check("R8 fetch after nack ignored", {8'h00, rd_byte}, 16'h00FF);

        // R9 repeated start keeps pointer (input port 1)
        pulse_start_rd();
        fetch();
        check("R9 repeated start pointer", {8'h00, rd_byte}, 16'h00A5);

        // R9 idle ignores strobes
        pulse_stop();
        put(8'h55);
        fetch();
        check("R9 idle write ignored", pin_od, 16'h3CA5);
        check("R9 idle fetch ignored", {8'h00, rd_byte}, 16'h00A5);

        // R5 direction pair readback
        pulse_start_wr(); put(8'h07);
        pulse_start_rd();
        fetch();
        check("R5 read direction port1", {8'h00, rd_byte}, 16'h000F);
        ack(1'b1);
        fetch();
        check("R5 read direction port0", {8'h00, rd_byte}, 16'h00F0);
        pulse_stop();

        // mixed random traffic checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 11);
            @(negedge clk) begin
                pin_in = 16'($urandom);
                wr_byte = 8'($urandom);
                rd_acked = 1'($urandom);
                start_wr = (r == 0);
                start_rd = (r == 1);
                stop = (r == 2);
                wr_stb = (r >= 3 && r <= 6);
                rd_stb = (r == 7 || r == 8);
                rd_ack_stb = (r == 9);
            end
        end
        @(negedge clk) begin
            start_wr = 0; start_rd = 0; stop = 0;
            wr_stb = 0; rd_stb = 0; rd_ack_stb = 0;
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule